// File: doc/BRIEF.md
# Dependence-Based FIFO Steering Unit

This unit stands in for an associative issue window. Renamed instructions arrive in groups of up to four and are written into one of eight in-order queues. The queue is chosen so that an instruction follows its pending producer in the same queue whenever it can. Each queue issues only from its front, so readiness is checked at eight places instead of across a whole window.

A chaining table, indexed by logical register, records the queue and the physical tag of the newest pending writer of that register. An entry stops counting as pending once that writer issues. A busy bit per physical register is raised when a producer is steered and dropped when a writeback port reports its tag. The instruction at the front of a queue leaves when both of its physical source bits are clear. The upstream stage offers a group and reads back how many leading slots were taken. It offers the rest again in a later cycle.

Top module: `dep_steer_unit`

## Requirements
- R1: After reset every queue is empty, `fifo_empty` is all ones, `iss_valid` is zero and no chaining entry is pending.
- R2: An instruction with neither logical source pending goes to the empty queue with the lowest index.
- R3: An instruction with exactly one pending source joins that producer's queue when the producer is the newest entry there and the queue holds fewer than 8 entries. Otherwise it takes the lowest-indexed empty queue.
- R4: With two pending sources, the first source's producer queue is tried first, then the second's, each under the R3 condition. The lowest-indexed empty queue is the fallback.
- R5: When an instruction finds no legal queue it stalls. It and every younger slot of the group are refused, and the older slots still go. `in_taken` gives the number of accepted leading slots.
- R6: Slots are steered in order 0 to 3. Each slot sees the chaining, newest-entry and occupancy changes made by older slots of the same group.
- R7: Each queue issues in order, at most one instruction per cycle, and only from a non-empty queue. The front entry issues in the cycle after both of its physical source busy bits read clear. A busy second source alone holds it.
- R8: A busy bit is set when its producer is steered. It is cleared by a matching tag on either writeback port, taking effect on the following cycle.
- R9: Only a contiguous run of valid slots starting at slot 0 can be accepted. A gap ends the group.
- R10: `in_fifo` gives the chosen queue index for each accepted slot and zero for the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 4 | Slot valid, slot 0 oldest |
| in_ls1 | input | 16 | First logical source per slot, 4 bits each |
| in_ls2 | input | 16 | Second logical source per slot |
| in_ld | input | 16 | Logical destination per slot |
| in_ps1 | input | 24 | First physical source per slot, 6 bits each |
| in_ps2 | input | 24 | Second physical source per slot |
| in_pd | input | 24 | Physical destination per slot |
| in_taken | output | 3 | Number of accepted leading slots |
| in_fifo | output | 12 | Chosen queue per slot, 3 bits each |
| wb_valid | input | 2 | Writeback port valid |
| wb_tag | input | 12 | Writeback physical tag per port |
| iss_valid | output | 8 | Queue front issues this cycle |
| iss_pd | output | 48 | Destination tag issued per queue, zero when idle |
| fifo_empty | output | 8 | Queue holds no entry |

## Verification
On every cycle the checker confirms the following. The accepted count never exceeds the leading run of valid slots. No empty queue issues. An empty queue that receives no accepted slot stays empty. All queues come out of reset empty and idle. The choice of queue under the heuristic, the in-group visibility of older slots, the stall ordering and the gating of the front entry by busy bits and writebacks depend on particular instruction sequences. Only the bench's scenarios can show them, with queue choices and issue order worked out by hand.

// File: rtl/dsu_pkg.sv
package dsu_pkg;
    parameter int unsigned NQ     = 8;   // number of in-order queues
    parameter int unsigned QDEPTH = 8;   // entries per queue, power of two
    parameter int unsigned GRP    = 4;   // steering slots per cycle
    parameter int unsigned NLREG  = 16;  // logical registers
    parameter int unsigned NPREG  = 64;  // physical registers
    parameter int unsigned NWB    = 2;   // writeback ports

    localparam int unsigned QW   = $clog2(NQ);
    localparam int unsigned PTRW = $clog2(QDEPTH);
    localparam int unsigned CW   = $clog2(QDEPTH + 1);
    localparam int unsigned LW   = $clog2(NLREG);
    localparam int unsigned PW   = $clog2(NPREG);
    localparam int unsigned GW   = $clog2(GRP + 1);

    typedef logic [PW-1:0] ptag_t;
    typedef logic [LW-1:0] lreg_t;
    typedef logic [QW-1:0] qid_t;
    typedef logic [CW-1:0] qcnt_t;

    typedef struct packed {
        ptag_t ps1;
        ptag_t ps2;
        ptag_t pd;
    } uop_t;

    typedef struct packed {
        lreg_t ls1;
        lreg_t ls2;
        lreg_t ld;
        uop_t  u;
    } dslot_t;

    typedef struct packed {
        logic  pend;
        qid_t  q;
        ptag_t pd;
    } link_t;

    // producer still pending, newest entry in its queue, and room behind it
    function automatic logic can_chain(link_t e, qcnt_t c, ptag_t newest);
        return e.pend && (c != '0) && (c < CW'(QDEPTH)) && (newest == e.pd);
    endfunction
endpackage

// File: rtl/dsu_steer.sv
module dsu_steer
    import dsu_pkg::*;
(
    input  logic [GRP-1:0] vld,
    input  dslot_t         slot   [GRP],
    input  link_t          map_i  [NLREG],
    input  qcnt_t          cnt_i  [NQ],
    input  ptag_t          tail_i [NQ],
    output logic [GRP-1:0] go,
    output qid_t           qsel   [GRP],
    output logic [GW-1:0]  taken,
    output link_t          map_o  [NLREG]
);
    qcnt_t wc [NQ];
    ptag_t wt [NQ];
    link_t e1, e2;
    logic  stop, found;
    qid_t  pick;

    always_comb begin
        map_o = map_i;
        wc    = cnt_i;
        wt    = tail_i;
        stop  = 1'b0;
        taken = '0;
        go    = '0;
        e1    = '0;
        e2    = '0;
        found = 1'b0;
        pick  = '0;
        for (int k = 0; k < GRP; k++) begin
            qsel[k] = '0;
            found   = 1'b0;
            pick    = '0;
            e1      = map_o[slot[k].ls1];
            e2      = map_o[slot[k].ls2];
            if (vld[k] && !stop) begin
                if (can_chain(e1, wc[e1.q], wt[e1.q])) begin
                    found = 1'b1;
                    pick  = e1.q;
                end else if (can_chain(e2, wc[e2.q], wt[e2.q])) begin
                    found = 1'b1;
                    pick  = e2.q;
                end else begin
                    for (int f = NQ - 1; f >= 0; f--) begin
                        if (wc[f] == '0) begin
                            found = 1'b1;
                            pick  = qid_t'(f);
                        end
                    end
                end
                if (found) begin
                    go[k]             = 1'b1;
                    qsel[k]           = pick;
                    taken             = taken + GW'(1);
                    wc[pick]          = wc[pick] + CW'(1);
                    wt[pick]          = slot[k].u.pd;
                    map_o[slot[k].ld] = '{pend: 1'b1, q: pick, pd: slot[k].u.pd};
                end else begin
                    stop = 1'b1;
                end
            end else begin
                stop = 1'b1;
            end
        end
    end
endmodule

// File: rtl/dsu_queue.sv
module dsu_queue
    import dsu_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic [GRP-1:0] push,
    input  uop_t           din [GRP],
    input  logic           pop,
    output uop_t           head,
    output qcnt_t          cnt,
    output ptag_t          tail
);
    typedef logic [PTRW-1:0] ptr_t;

    uop_t  mem [QDEPTH];
    ptr_t  rp, wp;
    ptr_t  widx [GRP];
    qcnt_t npush;

    always_comb begin
        npush = '0;
        for (int k = 0; k < GRP; k++) begin
            widx[k] = wp + ptr_t'(npush);
            if (push[k]) npush = npush + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        for (int k = 0; k < GRP; k++)
            if (push[k]) mem[widx[k]] <= din[k];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rp   <= '0;
            wp   <= '0;
            cnt  <= '0;
            tail <= '0;
        end else begin
            wp  <= wp + ptr_t'(npush);
            rp  <= rp + ptr_t'(pop);
            cnt <= cnt + npush - qcnt_t'(pop);
            for (int k = 0; k < GRP; k++)
                if (push[k]) tail <= din[k].pd;
        end
    end

    assign head = mem[rp];
endmodule

// File: rtl/dsu_resv.sv
module dsu_resv
    import dsu_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [GRP-1:0]   set_v,
    input  ptag_t            set_tag [GRP],
    input  logic [NWB-1:0]   wb_v,
    input  ptag_t            wb_t    [NWB],
    output logic [NPREG-1:0] busy
);
    logic [NPREG-1:0] set_vec, clr_vec;

    always_comb begin
        set_vec = '0;
        clr_vec = '0;
        for (int k = 0; k < GRP; k++)
            if (set_v[k]) set_vec[set_tag[k]] = 1'b1;
        for (int w = 0; w < NWB; w++)
            if (wb_v[w]) clr_vec[wb_t[w]] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) busy <= '0;
        else     busy <= (busy & ~clr_vec) | set_vec;
    end
endmodule

// File: rtl/dep_steer_unit.sv
module dep_steer_unit
    import dsu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [GRP-1:0]    in_valid,
    input  logic [GRP*LW-1:0] in_ls1,
    input  logic [GRP*LW-1:0] in_ls2,
    input  logic [GRP*LW-1:0] in_ld,
    input  logic [GRP*PW-1:0] in_ps1,
    input  logic [GRP*PW-1:0] in_ps2,
    input  logic [GRP*PW-1:0] in_pd,
    output logic [GW-1:0]     in_taken,
    output logic [GRP*QW-1:0] in_fifo,
    input  logic [NWB-1:0]    wb_valid,
    input  logic [NWB*PW-1:0] wb_tag,
    output logic [NQ-1:0]     iss_valid,
    output logic [NQ*PW-1:0]  iss_pd,
    output logic [NQ-1:0]     fifo_empty
);
    dslot_t           slot  [GRP];
    uop_t             uops  [GRP];
    ptag_t            ptags [GRP];
    ptag_t            wbt   [NWB];
    link_t            map_q  [NLREG];
    link_t            map_n  [NLREG];
    link_t            map_nx [NLREG];
    logic [GRP-1:0]   go;
    qid_t             qsel  [GRP];
    uop_t             heads [NQ];
    qcnt_t            cnts  [NQ];
    ptag_t            tails [NQ];
    ptag_t            iss_tag [NQ];
    logic [NPREG-1:0] busy;

    for (genvar k = 0; k < GRP; k++) begin : g_slot
        assign slot[k] = {in_ls1[k*LW +: LW], in_ls2[k*LW +: LW], in_ld[k*LW +: LW],
                          in_ps1[k*PW +: PW], in_ps2[k*PW +: PW], in_pd[k*PW +: PW]};
        assign uops[k]  = slot[k].u;
        assign ptags[k] = slot[k].u.pd;
        assign in_fifo[k*QW +: QW] = qsel[k];
    end

    for (genvar w = 0; w < NWB; w++) begin : g_wb
        assign wbt[w] = wb_tag[w*PW +: PW];
    end

    dsu_steer i_steer (
        .vld    (in_valid),
        .slot   (slot),
        .map_i  (map_q),
        .cnt_i  (cnts),
        .tail_i (tails),
        .go     (go),
        .qsel   (qsel),
        .taken  (in_taken),
        .map_o  (map_n)
    );

    for (genvar f = 0; f < NQ; f++) begin : g_q
        logic [GRP-1:0] push;
        always_comb
            for (int k = 0; k < GRP; k++)
                push[k] = go[k] && (qsel[k] == qid_t'(f));

        dsu_queue i_queue (
            .clk  (clk),
            .rst  (rst),
            .push (push),
            .din  (uops),
            .pop  (iss_valid[f]),
            .head (heads[f]),
            .cnt  (cnts[f]),
            .tail (tails[f])
        );

        assign fifo_empty[f]        = (cnts[f] == '0);
        assign iss_valid[f]         = !fifo_empty[f] && !busy[heads[f].ps1] && !busy[heads[f].ps2];
        assign iss_tag[f]           = heads[f].pd;
        assign iss_pd[f*PW +: PW]   = iss_valid[f] ? heads[f].pd : '0;
    end

    dsu_resv i_resv (
        .clk     (clk),
        .rst     (rst),
        .set_v   (go),
        .set_tag (ptags),
        .wb_v    (wb_valid),
        .wb_t    (wbt),
        .busy    (busy)
    );

    // a chaining entry stops being pending once its producer leaves its queue
    always_comb begin
        for (int r = 0; r < NLREG; r++) begin
            map_nx[r] = map_n[r];
            for (int f = 0; f < NQ; f++)
                if (iss_valid[f] && (iss_tag[f] == map_n[r].pd)) map_nx[r].pend = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        for (int r = 0; r < NLREG; r++) begin
            if (rst) map_q[r] <= '0;
            else     map_q[r] <= map_nx[r];
        end
    end
endmodule

// File: rtl/dsu_chk.sv
module dsu_chk
    import dsu_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [GRP-1:0]    in_valid,
    input logic [GW-1:0]     in_taken,
    input logic [GRP*QW-1:0] in_fifo,
    input logic [NQ-1:0]     iss_valid,
    input logic [NQ-1:0]     fifo_empty
);
    logic [GW-1:0] lead;
    logic          run;
    logic [NQ-1:0] hit;

    always_comb begin
        lead = '0;
        run  = 1'b1;
        for (int k = 0; k < GRP; k++) begin
            run = run & in_valid[k];
            if (run) lead = lead + GW'(1);
        end
    end

    always_comb begin
        hit = '0;
        for (int k = 0; k < GRP; k++)
            if (k < int'(in_taken)) hit[in_fifo[k*QW +: QW]] = 1'b1;
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (fifo_empty == '1 && iss_valid == '0));

    // R5
    taken_bound_chk: assert property (@(posedge clk) disable iff (rst)
        in_taken <= GW'($countones(in_valid)));

    // R9
    taken_prefix_chk: assert property (@(posedge clk) disable iff (rst)
        in_taken <= lead);

    // R7
    issue_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
        (iss_valid & fifo_empty) == '0);

    for (genvar f = 0; f < NQ; f++) begin : g_hold
        // R7
        empty_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (fifo_empty[f] && !hit[f]) |=> fifo_empty[f]);
    end
endmodule

bind dep_steer_unit dsu_chk i_dsu_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_taken   (in_taken),
    .in_fifo    (in_fifo),
    .iss_valid  (iss_valid),
    .fifo_empty (fifo_empty)
);

// File: tb/test_dep_steer_unit.sv
module test_dep_steer_unit;
    import dsu_pkg::*;

    logic              clk = 1'b0;
    logic              rst;
    logic [GRP-1:0]    in_valid;
    logic [GRP*LW-1:0] in_ls1, in_ls2, in_ld;
    logic [GRP*PW-1:0] in_ps1, in_ps2, in_pd;
    logic [GW-1:0]     in_taken;
    logic [GRP*QW-1:0] in_fifo;
    logic [NWB-1:0]    wb_valid;
    logic [NWB*PW-1:0] wb_tag;
    logic [NQ-1:0]     iss_valid, fifo_empty;
    logic [NQ*PW-1:0]  iss_pd;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;   // 250 MHz

    dep_steer_unit i_dep_steer_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .in_ls1(in_ls1), .in_ls2(in_ls2), .in_ld(in_ld),
        .in_ps1(in_ps1), .in_ps2(in_ps2), .in_pd(in_pd),
        .in_taken(in_taken), .in_fifo(in_fifo),
        .wb_valid(wb_valid), .wb_tag(wb_tag),
        .iss_valid(iss_valid), .iss_pd(iss_pd), .fifo_empty(fifo_empty)
    );

    // one slot: logical sources, logical dest, physical dest, expected queue
    typedef struct packed {
        logic [3:0] l1;
        logic [3:0] l2;
        logic [3:0] ld;
        logic [5:0] pd;
        logic [2:0] q;
    } sl_t;

    typedef struct packed {
        logic [2:0] taken;
        sl_t s0;
        sl_t s1;
        sl_t s2;
        sl_t s3;
    } row_t;

    // every row: all four slots valid, physical sources p60 and p0
    localparam row_t ROWS [6] = '{
        '{4, '{1, 2, 3, 1, 0},  '{3, 4, 5, 2, 0},   '{3, 9, 6, 3, 1},   '{5, 6, 7, 4, 0}},
        '{4, '{6, 5, 8, 5, 1},  '{5, 8, 9, 6, 1},   '{0, 0, 10, 7, 2},  '{7, 7, 11, 8, 0}},
        '{4, '{11, 0, 12, 9, 0}, '{12, 0, 13, 10, 0}, '{13, 0, 14, 11, 0}, '{14, 0, 1, 12, 0}},
        '{4, '{1, 0, 2, 13, 3}, '{0, 0, 15, 14, 4}, '{0, 0, 15, 15, 5}, '{0, 0, 15, 16, 6}},
        '{1, '{0, 0, 4, 17, 7}, '{0, 0, 4, 19, 0},  '{2, 0, 5, 20, 0},  '{0, 0, 6, 21, 0}},
        '{1, '{2, 0, 5, 18, 3}, '{0, 0, 6, 22, 0},  '{0, 0, 6, 23, 0},  '{0, 0, 6, 24, 0}}
    };

    task automatic chk(input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic put(input int k, input int l1, input int l2, input int ld,
                       input int p1, input int p2, input int pd);
        in_ls1[k*LW +: LW] = LW'(l1);
        in_ls2[k*LW +: LW] = LW'(l2);
        in_ld [k*LW +: LW] = LW'(ld);
        in_ps1[k*PW +: PW] = PW'(p1);
        in_ps2[k*PW +: PW] = PW'(p2);
        in_pd [k*PW +: PW] = PW'(pd);
    endtask

    function automatic int qof(input int k);
        return int'(in_fifo[k*QW +: QW]);
    endfunction

    function automatic int pdof(input int f);
        return int'(iss_pd[f*PW +: PW]);
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = '0;
        wb_valid = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 fifo_empty after reset", int'(fifo_empty), 255);
        chk("R1 iss_valid after reset", int'(iss_valid), 0);
        chk("R1 in_taken idle", int'(in_taken), 0);
    endtask

    initial begin
        rst = 1'b1;
        in_valid = '0;
        in_ls1 = '0; in_ls2 = '0; in_ld = '0;
        in_ps1 = '0; in_ps2 = '0; in_pd = '0;
        wb_valid = '0;
        wb_tag = '0;
        do_reset();

        // root producer of p60; it issues, leaving p60 busy as a blocker
        put(0, 0, 0, 15, 0, 0, 60);
        in_valid = 4'b0001;
        #1;
        chk("R2 root taken", int'(in_taken), 1);
        chk("R2 root queue", qof(0), 0);
        @(negedge clk);
        in_valid = '0;
        #1;
        chk("R7 root issues", int'(iss_valid), 1);
        chk("R8 root pd", pdof(0), 60);
        @(negedge clk);

        // table of groups: R2 R3 R4 R5 R6
        for (int r = 0; r < 6; r++) begin
            put(0, ROWS[r].s0.l1, ROWS[r].s0.l2, ROWS[r].s0.ld, 60, 0, ROWS[r].s0.pd);
            put(1, ROWS[r].s1.l1, ROWS[r].s1.l2, ROWS[r].s1.ld, 60, 0, ROWS[r].s1.pd);
            put(2, ROWS[r].s2.l1, ROWS[r].s2.l2, ROWS[r].s2.ld, 60, 0, ROWS[r].s2.pd);
            put(3, ROWS[r].s3.l1, ROWS[r].s3.l2, ROWS[r].s3.ld, 60, 0, ROWS[r].s3.pd);
            in_valid = 4'b1111;
            #1;
            chk($sformatf("R5 row %0d taken", r), int'(in_taken), int'(ROWS[r].taken));
            if (ROWS[r].taken > 0) chk($sformatf("R3 R4 row %0d slot0 queue", r), qof(0), int'(ROWS[r].s0.q));
            if (ROWS[r].taken > 1) chk($sformatf("R6 row %0d slot1 queue", r), qof(1), int'(ROWS[r].s1.q));
            if (ROWS[r].taken > 2) chk($sformatf("R6 row %0d slot2 queue", r), qof(2), int'(ROWS[r].s2.q));
            if (ROWS[r].taken > 3) chk($sformatf("R6 row %0d slot3 queue", r), qof(3), int'(ROWS[r].s3.q));
            if (ROWS[r].taken < 4) chk($sformatf("R10 row %0d refused slot queue", r), qof(3), 0);
            @(negedge clk);
        end

        in_valid = '0;
        #1;
        chk("R7 all queues occupied", int'(fifo_empty), 0);
        chk("R8 fronts held by busy p60", int'(iss_valid), 0);

        // writeback of p60 frees every front
        wb_valid = 2'b01;
        wb_tag   = {6'd0, 6'd60};
        @(negedge clk);
        wb_valid = '0;
        #1;
        chk("R8 all fronts issue after writeback", int'(iss_valid), 255);
        chk("R7 q0 front", pdof(0), 1);
        chk("R7 q1 front", pdof(1), 3);
        chk("R7 q2 front", pdof(2), 7);
        chk("R7 q3 front", pdof(3), 13);
        chk("R7 q7 front", pdof(7), 17);
        @(negedge clk);
        #1;
        chk("R7 second wave", int'(iss_valid), 11);
        chk("R7 q0 second", pdof(0), 2);
        chk("R7 q1 second", pdof(1), 5);
        chk("R7 q3 second", pdof(3), 18);
        @(negedge clk);
        #1;
        chk("R7 third wave", int'(iss_valid), 3);
        chk("R7 q0 third", pdof(0), 4);
        chk("R7 q1 third", pdof(1), 6);

        // directed: second-source gating and both writeback ports
        do_reset();
        put(0, 0, 0, 3, 0, 0, 41);
        put(1, 0, 0, 9, 41, 0, 40);
        put(2, 0, 0, 1, 0, 0, 20);
        in_valid = 4'b0111;
        #1;
        chk("R9 partial group taken", int'(in_taken), 3);
        chk("R2 slot0 queue", qof(0), 0);
        chk("R6 slot1 queue", qof(1), 1);
        chk("R6 slot2 queue", qof(2), 2);
        @(negedge clk);
        put(0, 9, 0, 7, 0, 20, 21);
        in_valid = 4'b0001;
        #1;
        chk("R7 ready fronts issue", int'(iss_valid), 5);
        chk("R7 q0 pd", pdof(0), 41);
        chk("R7 q2 pd", pdof(2), 20);
        chk("R3 chain behind pending producer", qof(0), 1);
        @(negedge clk);
        in_valid = '0;
        #1;
        chk("R8 front waits on busy first source", int'(iss_valid), 0);
        wb_valid = 2'b01;
        wb_tag   = {6'd0, 6'd41};
        @(negedge clk);
        wb_valid = '0;
        #1;
        chk("R8 port0 writeback frees front", int'(iss_valid), 2);
        chk("R8 q1 pd", pdof(1), 40);
        @(negedge clk);
        #1;
        chk("R7 busy second source holds front", int'(iss_valid), 0);
        wb_valid = 2'b10;
        wb_tag   = {6'd20, 6'd0};
        @(negedge clk);
        wb_valid = '0;
        #1;
        chk("R8 port1 writeback frees front", int'(iss_valid), 2);
        chk("R8 q1 pd after port1", pdof(1), 21);
        @(negedge clk);
        #1;
        chk("R7 queues drained", int'(fifo_empty), 255);

        // gap in valid slots ends the group
        put(0, 0, 0, 2, 0, 0, 30);
        put(1, 0, 0, 2, 0, 0, 31);
        put(2, 0, 0, 2, 0, 0, 32);
        put(3, 0, 0, 2, 0, 0, 33);
        in_valid = 4'b1101;
        #1;
        chk("R9 gap stops group", int'(in_taken), 1);
        chk("R2 lowest empty queue", qof(0), 0);
        chk("R10 refused slot reports zero", qof(2), 0);
        @(negedge clk);
        in_valid = '0;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule